// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block keeps stores that have entered the pipeline but have not yet been written to memory. They are held in program order in an eight-entry ring. Each store is accepted with its address, data and access size. Later it is marked done by the pipeline and, once it is the oldest entry, it is handed to the memory side. Stores younger than a mispredicted path can be cut off the queue with a flush, which rewinds the tail pointer.

Loads query the queue combinationally. A load carries the tail pointer that was current when it was dispatched, so only stores older than the load are searched. The youngest of those older stores whose bytes touch the load decides the outcome. If that store holds every load byte, its data is shifted into place and returned. If it holds only some of the bytes, a conflict is reported. If no older store touches the load, the load is told to read memory. Addresses are compared on their low twelve bits only.

The enqueue and drain paths are valid/ready streams. An enqueue is accepted in a cycle where `enq_valid` and `enq_ready` are both high. The drain side holds its payload steady until `mem_ready` is seen. The done, flush and lookup pins are plain, single-cycle controls.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `tail_ptr` is 0, `full` is low, `mem_valid` is low and `enq_ready` is high.
- R2: An enqueue is accepted when `enq_valid` and `enq_ready` are both high. The store goes into slot `tail_ptr[2:0]` and `tail_ptr` (a 4-bit pointer with a wrap bit) advances by one.
- R3: With 8 entries held, `full` is high and `enq_ready` is low, and an offered store is not taken: `tail_ptr` does not move.
- R4: `mem_valid` is high when the oldest entry is marked done, and it presents that entry's address, data and size. While `mem_ready` is low these outputs hold. Each handshake removes exactly that oldest entry, so stores leave in program order.
- R5: A `done_valid` pulse with `done_idx` marks the entry in that slot as done, which lets it drain once it is oldest.
- R6: While `ld_valid` is high, exactly one of `ld_hit`, `ld_mem` and `ld_conflict` is high. Only entries between the head and `ld_tail` take part in the search.
- R7: A store matches a load using address bits 11:0 only. Addresses that differ only above bit 11 still match. Byte ranges are formed on those 12 bits without wrapping past 0xFFF.
- R8: Size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes. On a hit, `ld_data` byte k equals the deciding store's byte (load address − store address + k), and all bytes above the load size are zero.
- R9: If the deciding store overlaps some but not all load bytes, `ld_conflict` is high and `ld_hit` is low.
- R10: When several older stores overlap the load, the youngest of them decides the result.
- R11: A `flush_valid` pulse sets `tail_ptr` to `flush_tail`, dropping every entry from there to the old tail. `enq_ready` is low in that cycle.
- R12: A lookup sees the queue as it stands before the clock edge, so an entry that drains in the same cycle still forwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Store offered |
| enq_ready | output | 1 | Store can be accepted |
| enq_addr | input | 32 | Store byte address |
| enq_data | input | 64 | Store data, byte 0 in bits 7:0 |
| enq_size | input | 2 | Store size code |
| done_valid | input | 1 | Mark an entry done |
| done_idx | input | 3 | Slot to mark |
| mem_valid | output | 1 | Oldest store ready for memory |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | 32 | Draining store address |
| mem_data | output | 64 | Draining store data |
| mem_size | output | 2 | Draining store size code |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_tail | input | 4 | Tail pointer captured at load dispatch |
| ld_hit | output | 1 | Load fully forwarded |
| ld_data | output | 64 | Forwarded data, zero-extended |
| ld_mem | output | 1 | Load must read memory |
| ld_conflict | output | 1 | Partial overlap with the deciding store |
| flush_valid | input | 1 | Rewind the tail |
| flush_tail | input | 4 | New tail pointer |
| tail_ptr | output | 4 | Current tail pointer, low bits give the next slot |
| full | output | 1 | All 8 entries held |

## Verification
Two pairs of functions can land in the same cycle. A drain can coincide with a lookup that hits the draining entry. An enqueue or drain can coincide with a flush. Both pairs are provoked directly, and random traffic then brings them together many more times. A behavioural model, built from queues of integers and byte-by-byte overlap scans, predicts every output on every clock. The forwarding result is judged in the cycle of the drain. The tail is judged on the cycle after a flush, together with the `enq_ready` that was refused during it.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Access size code: width in bytes is 1 << code
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_fire,
  input  logic          drain_fire,
  input  logic          flush_valid,
  input  logic [PW-1:0] flush_tail,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic [PW-1:0] count,
  output logic          full
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (drain_fire) head_ptr <= head_ptr + 1'b1;
      if (flush_valid)   tail_ptr <= flush_tail;
      else if (enq_fire) tail_ptr <= tail_ptr + 1'b1;
    end
  end

  assign count = tail_ptr - head_ptr;
  assign full  = (count == DEPTH_P);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_P); // R3
  AST_ENQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_fire && !flush_valid) |=> (tail_ptr == $past(tail_ptr) + 1'b1)); // R2
endmodule

// File: rtl/sq_storage.sv
module sq_storage #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_size,
  input  logic          mark_en,
  input  logic [IW-1:0] mark_idx,
  output logic [AW-1:0] addr_q [DEPTH],
  output logic [DW-1:0] data_q [DEPTH],
  output logic [1:0]    size_q [DEPTH],
  output logic          done_q [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
        size_q[g] <= '0;
        done_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        addr_q[g] <= wr_addr;
        data_q[g] <= wr_data;
        size_q[g] <= wr_size;
        done_q[g] <= 1'b0;
      end else if (mark_en && mark_idx == IW'(g)) begin
        done_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_fwd.sv
module sq_fwd
  import sq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int MATCH_W = 12,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1,
  localparam int EW = MATCH_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] head_ptr,
  input  logic [PW-1:0] count,
  input  logic [AW-1:0] addr_q [DEPTH],
  input  logic [DW-1:0] data_q [DEPTH],
  input  logic [1:0]    size_q [DEPTH],
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic [PW-1:0] ld_tail,
  output logic          ld_hit,
  output logic          ld_mem,
  output logic          ld_conflict,
  output logic [DW-1:0] ld_data
);
  logic [PW-1:0] lim;
  logic [EW-1:0] ld_lo, ld_hi;
  logic          found, covers;
  logic [IW-1:0] sel;
  logic [2:0]    off;
  logic [DW-1:0] shifted, keep;

  // Scan oldest to youngest; the last overlapping older entry wins
  always_comb begin
    lim = ld_tail - head_ptr;
    if (lim > count) lim = count;
    ld_lo  = {1'b0, ld_addr[MATCH_W-1:0]};
    ld_hi  = ld_lo + EW'(size_bytes(ld_size));
    found  = 1'b0;
    covers = 1'b0;
    sel    = '0;
    off    = '0;
    for (int r = 0; r < DEPTH; r++) begin
      logic [IW-1:0] slot;
      logic [EW-1:0] st_lo, st_hi;
      slot  = head_ptr[IW-1:0] + IW'(r);
      st_lo = {1'b0, addr_q[slot][MATCH_W-1:0]};
      st_hi = st_lo + EW'(size_bytes(size_q[slot]));
      if (PW'(r) < lim && st_lo < ld_hi && ld_lo < st_hi) begin
        found  = 1'b1;
        covers = (st_lo <= ld_lo) && (ld_hi <= st_hi);
        sel    = slot;
        off    = 3'(ld_lo - st_lo);
      end
    end
  end

  always_comb begin
    unique case (ld_size)
      2'd0:    keep = DW'(8'hFF);
      2'd1:    keep = DW'(16'hFFFF);
      2'd2:    keep = DW'(32'hFFFF_FFFF);
      default: keep = '1;
    endcase
    shifted = data_q[sel] >> {off, 3'b000};
  end

  assign ld_hit      = ld_valid && found && covers;
  assign ld_conflict = ld_valid && found && !covers;
  assign ld_mem      = ld_valid && !found;
  assign ld_data     = ld_hit ? (shifted & keep) : '0;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($countones({ld_hit, ld_mem, ld_conflict}) == 1)); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !(ld_hit || ld_mem || ld_conflict)); // R6
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit && ld_size == 2'd0) |-> (ld_data[DW-1:8] == '0)); // R8
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && count == '0) |-> ld_mem); // R6
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
  parameter int DEPTH   = 8,
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int MATCH_W = 12,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  input  logic [1:0]    enq_size,
  input  logic          done_valid,
  input  logic [IW-1:0] done_idx,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [1:0]    mem_size,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic [PW-1:0] ld_tail,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          ld_mem,
  output logic          ld_conflict,
  input  logic          flush_valid,
  input  logic [PW-1:0] flush_tail,
  output logic [PW-1:0] tail_ptr,
  output logic          full
);
  logic [PW-1:0] head_ptr, count;
  logic          enq_fire, drain_fire;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [1:0]    size_q [DEPTH];
  logic          done_q [DEPTH];
  logic [IW-1:0] head_idx;

  assign head_idx   = head_ptr[IW-1:0];
  assign enq_ready  = !full && !flush_valid;
  assign enq_fire   = enq_valid && enq_ready;
  assign mem_valid  = (count != '0) && done_q[head_idx];
  assign drain_fire = mem_valid && mem_ready;
  assign mem_addr   = addr_q[head_idx];
  assign mem_data   = data_q[head_idx];
  assign mem_size   = size_q[head_idx];

  sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk, .rst_n,
    .enq_fire, .drain_fire, .flush_valid, .flush_tail,
    .head_ptr, .tail_ptr, .count, .full
  );

  sq_storage #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_mem (
    .clk, .rst_n,
    .wr_en(enq_fire), .wr_idx(tail_ptr[IW-1:0]),
    .wr_addr(enq_addr), .wr_data(enq_data), .wr_size(enq_size),
    .mark_en(done_valid), .mark_idx(done_idx),
    .addr_q, .data_q, .size_q, .done_q
  );

  sq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MATCH_W(MATCH_W)) u_fwd (
    .clk, .rst_n,
    .head_ptr, .count, .addr_q, .data_q, .size_q,
    .ld_valid, .ld_addr, .ld_size, .ld_tail,
    .ld_hit, .ld_mem, .ld_conflict, .ld_data
  );

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !enq_ready); // R3
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_size))); // R4
  AST_FLUSH_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (tail_ptr == $past(flush_tail))); // R11
  AST_FLUSH_NO_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !enq_ready); // R11
endmodule

// File: tb/tb_store_fwd_queue.sv
module tb_store_fwd_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid, enq_ready;
  logic [31:0] enq_addr;
  logic [63:0] enq_data;
  logic [1:0]  enq_size;
  logic        done_valid;
  logic [2:0]  done_idx;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;
  logic [1:0]  mem_size;
  logic        ld_valid;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic [3:0]  ld_tail;
  logic        ld_hit, ld_mem, ld_conflict;
  logic [63:0] ld_data;
  logic        flush_valid;
  logic [3:0]  flush_tail;
  logic [3:0]  tail_ptr;
  logic        full;

  always #2 clk = ~clk;

  store_fwd_queue dut (
    .clk, .rst_n,
    .enq_valid, .enq_ready, .enq_addr, .enq_data, .enq_size,
    .done_valid, .done_idx,
    .mem_valid, .mem_ready, .mem_addr, .mem_data, .mem_size,
    .ld_valid, .ld_addr, .ld_size, .ld_tail,
    .ld_hit, .ld_data, .ld_mem, .ld_conflict,
    .flush_valid, .flush_tail, .tail_ptr, .full
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  // Reference model: slots by pointer value, pointers as plain integers
  int          m_head = 0, m_tail = 0;
  logic [31:0] m_addr [8];
  logic [63:0] m_data [8];
  int          m_size [8];
  bit          m_done [8];
  bit          e_hit, e_mem, e_conf;
  logic [63:0] e_data;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_lookup(input logic [31:0] la, input int lsz, input int ltail);
    int cnt, lim, lb, ln;
    cnt = m_tail - m_head;
    lim = (ltail - (m_head % 16) + 16) % 16;
    if (lim > cnt) lim = cnt;
    lb = int'(la[11:0]);
    ln = 1 << lsz;
    e_hit = 0; e_mem = 1; e_conf = 0; e_data = '0;
    for (int r = lim - 1; r >= 0; r--) begin
      int s, sb, sn, ov;
      s  = (m_head + r) % 8;
      sb = int'(m_addr[s][11:0]);
      sn = 1 << m_size[s];
      ov = 0;
      for (int k = 0; k < ln; k++)
        if (lb + k >= sb && lb + k < sb + sn) ov++;
      if (ov > 0) begin
        e_mem = 0;
        if (ov == ln) begin
          e_hit = 1;
          for (int k = 0; k < ln; k++)
            e_data[8*k +: 8] = m_data[s][8*(lb + k - sb) +: 8];
        end else begin
          e_conf = 1;
        end
        break;
      end
    end
  endtask

  // Compare every output against the model, then advance the model
  task automatic step();
    int cnt, oh, s;
    bit e_full, e_rdy, e_mv;
    #1;
    cnt    = m_tail - m_head;
    e_full = (cnt == 8);
    e_rdy  = !e_full && !flush_valid;
    e_mv   = (cnt > 0) && m_done[m_head % 8];
    chk("R3", "full", 64'(full), 64'(e_full));
    chk("R3", "enq_ready", 64'(enq_ready), 64'(e_rdy));
    chk("R2", "tail_ptr", 64'(tail_ptr), 64'(m_tail % 16));
    chk("R4", "mem_valid", 64'(mem_valid), 64'(e_mv));
    if (e_mv) begin
      s = m_head % 8;
      chk("R4", "mem_addr", 64'(mem_addr), 64'(m_addr[s]));
      chk("R4", "mem_data", mem_data, m_data[s]);
      chk("R4", "mem_size", 64'(mem_size), 64'(m_size[s]));
    end
    if (ld_valid) begin
      model_lookup(ld_addr, int'(ld_size), int'(ld_tail));
      chk("R6", "ld_hit", 64'(ld_hit), 64'(e_hit));
      chk("R6", "ld_mem", 64'(ld_mem), 64'(e_mem));
      chk("R9", "ld_conflict", 64'(ld_conflict), 64'(e_conf));
      if (e_hit) chk("R8", "ld_data", ld_data, e_data);
    end
    oh = m_head;
    if (e_mv && mem_ready) m_head++;
    if (done_valid) m_done[done_idx] = 1;
    if (flush_valid) begin
      m_tail = oh + ((int'(flush_tail) - (oh % 16) + 16) % 16);
    end else if (enq_valid && e_rdy) begin
      s = m_tail % 8;
      m_addr[s] = enq_addr; m_data[s] = enq_data;
      m_size[s] = int'(enq_size); m_done[s] = 0;
      m_tail++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    enq_valid = 0; enq_addr = '0; enq_data = '0; enq_size = '0;
    done_valid = 0; done_idx = '0; mem_ready = 0;
    ld_valid = 0; ld_addr = '0; ld_size = '0; ld_tail = '0;
    flush_valid = 0; flush_tail = '0;
  endtask

  task automatic push(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz);
    enq_valid = 1; enq_addr = a; enq_data = d; enq_size = sz;
    step();
    enq_valid = 0;
  endtask

  task automatic rand_inputs();
    int cnt, hd, nr, r;
    cnt = m_tail - m_head;
    idle();
    enq_valid = ($urandom_range(0, 9) < 6);
    enq_addr  = {$urandom_range(0, 3) == 0 ? 20'h0 : 20'($urandom),
                 ($urandom_range(0, 19) == 0) ? 12'hFF8 + 12'($urandom_range(0, 7))
                                              : 12'h100 + 12'($urandom_range(0, 23))};
    enq_data  = {$urandom, $urandom};
    enq_size  = 2'($urandom_range(0, 3));
    mem_ready = ($urandom_range(0, 9) < 7);
    if (cnt > 0 && $urandom_range(0, 1) == 1) begin
      r = $urandom_range(0, cnt - 1);
      if (!m_done[(m_head + r) % 8]) begin
        done_valid = 1; done_idx = 3'((m_head + r) % 8);
      end
    end
    if ($urandom_range(0, 24) == 0) begin
      hd = -1;
      for (int i = 0; i < cnt; i++) if (m_done[(m_head + i) % 8]) hd = i;
      nr = $urandom_range(hd + 1, cnt);
      flush_valid = 1; flush_tail = 4'((m_head + nr) % 16);
    end
    if ($urandom_range(0, 9) < 8) begin
      ld_valid = 1;
      ld_size  = 2'($urandom_range(0, 3));
      ld_tail  = 4'((m_head + $urandom_range(0, cnt)) % 16);
      if (cnt > 0)
        ld_addr = {20'($urandom), m_addr[(m_head + $urandom_range(0, cnt - 1)) % 8][11:0]
                                  + 12'($urandom_range(0, 7)) - 12'd3};
      else
        ld_addr = $urandom;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1", "enq_ready", 64'(enq_ready), 64'd1);
    chk("R1", "full", 64'(full), 64'd0);
    chk("R1", "mem_valid", 64'(mem_valid), 64'd0);
    chk("R1", "tail_ptr", 64'(tail_ptr), 64'd0);
    step();

    // Two stores, the younger one sits on the upper half of the older
    push(32'hABCD_0100, 64'h8877_6655_4433_2211, 2'd3);
    push(32'h0000_0104, 64'h0000_0000_DDCC_BBAA, 2'd2);
    #1 chk("R2", "tail_ptr", 64'(tail_ptr), 64'd2);

    // Upper address bits differ; low 12 bits match
    ld_valid = 1; ld_addr = 32'h5555_0100; ld_size = 2'd1; ld_tail = 4'd2;
    #1;
    chk("R7", "ld_hit", 64'(ld_hit), 64'd1);
    chk("R8", "ld_data", ld_data, 64'h2211);
    step();
    ld_addr = 32'hABCD_0900; ld_size = 2'd0;
    #1 chk("R7", "ld_mem", 64'(ld_mem), 64'd1);
    step();
    // Youngest older store decides; an earlier tail hides it
    ld_addr = 32'h0000_0104; ld_size = 2'd2; ld_tail = 4'd2;
    #1 chk("R10", "ld_data", ld_data, 64'hDDCC_BBAA);
    step();
    ld_tail = 4'd1;
    #1 chk("R10", "ld_data", ld_data, 64'h8877_6655);
    step();
    // Partial overlap with the youngest older store
    ld_addr = 32'h0000_0102; ld_size = 2'd2; ld_tail = 4'd2;
    #1 chk("R9", "ld_conflict", 64'(ld_conflict), 64'd1);
    step();
    ld_tail = 4'd1;
    #1 chk("R9", "ld_data", ld_data, 64'h6655_4433);
    step();
    ld_addr = 32'h0000_0200; ld_size = 2'd3; ld_tail = 4'd2;
    #1 chk("R6", "ld_mem", 64'(ld_mem), 64'd1);
    step();
    ld_valid = 0;

    // Mark the oldest done, hold it under back-pressure, then drain
    done_valid = 1; done_idx = 3'd0;
    step();
    done_valid = 0;
    #1 chk("R5", "mem_valid", 64'(mem_valid), 64'd1);
    step();
    #1 chk("R4", "mem_addr", 64'(mem_addr), 64'hABCD_0100);
    step();
    mem_ready = 1;
    ld_valid = 1; ld_addr = 32'h0000_0100; ld_size = 2'd3; ld_tail = 4'd1;
    #1;
    chk("R12", "ld_hit", 64'(ld_hit), 64'd1);
    chk("R12", "ld_data", ld_data, 64'h8877_6655_4433_2211);
    step();
    mem_ready = 0;
    #1 chk("R12", "ld_mem", 64'(ld_mem), 64'd1);
    step();
    ld_valid = 0;

    // Flush back to one entry while an enqueue is offered
    push(32'h0000_0300, 64'h1, 2'd3);
    push(32'h0000_0308, 64'h2, 2'd3);
    push(32'h0000_0310, 64'h3, 2'd3);
    flush_valid = 1; flush_tail = 4'd2;
    enq_valid = 1; enq_addr = 32'h0000_0318; enq_data = 64'h4; enq_size = 2'd3;
    #1 chk("R11", "enq_ready", 64'(enq_ready), 64'd0);
    step();
    flush_valid = 0; enq_valid = 0;
    #1 chk("R11", "tail_ptr", 64'(tail_ptr), 64'd2);
    step();

    // Fill to the limit and offer one more
    for (int i = 0; i < 7; i++) push(32'h0000_0400 + 32'(8 * i), 64'(i), 2'd3);
    enq_valid = 1; enq_addr = 32'h0000_0500;
    #1;
    chk("R3", "full", 64'(full), 64'd1);
    chk("R3", "enq_ready", 64'(enq_ready), 64'd0);
    step();
    enq_valid = 0;
    #1 chk("R3", "tail_ptr", 64'(tail_ptr), 64'd9);
    step();

    for (int c = 0; c < 5000; c++) begin
      rand_inputs();
      step();
    end

    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule